// File: doc/BRIEF.md
# Transmit Link-State and Inter-Packet Gap Sequencer

This block sits between a byte-wide AXI4-Stream packet source and a line-side symbol output. Each clock cycle it emits one symbol, tagged with a type: a data byte, an idle, a remote-fault word or a local-fault word. Control inputs can force fault words or idles, or disable transmission altogether. A packet that has already started always runs to its end. Changes on the control inputs are acted on only between packets.

Between packets the sequencer holds off the source for a programmable inter-packet gap. The gap is enforced as an average rather than on every packet. A small bank of up to three bytes records how far earlier gaps ran past the target. A later gap may be shortened by the banked amount, which pays the bank back down. Every gap symbol counts toward the gap, whether it is an idle or a fault word.

The block has three states. `ST_INIT` is entered at reset and is left for `ST_GAP` once transmit enable is sampled high. `ST_GAP` goes to `ST_PKT` when it accepts a first byte that is not last; a single-byte packet keeps it in `ST_GAP`. `ST_PKT` returns to `ST_GAP` when it accepts the last byte. The symbol output is registered, so each symbol appears one cycle after the decision that produced it.

Top module: `tx_link_seq`

## Requirements
- R1: From reset the block is in its initial state. `link_init` is high, `s_tready` is low and `sym_type` is idle (code 0). It stays there until `tx_en` is sampled high, and `link_init` goes low on the next cycle.
- R2: Outside a packet, while `force_lf` is high, every output symbol is a local-fault word (code 3), even when `force_rf` is also high.
- R3: Outside a packet, while `force_rf` is high and `force_lf` is low, every output symbol is a remote-fault word (code 2).
- R4: Outside a packet, while `force_idle` is high or `tx_en` is low (and no fault is forced), only idles (code 0) are sent and `s_tready` stays low.
- R5: Once the first byte of a packet has been accepted, `s_tready` stays high until its last byte is accepted, whatever the control inputs do. If `tx_en` drops during a packet, that packet completes and no further packet is accepted.
- R6: Each accepted byte appears one cycle after acceptance as a data symbol (code 1) carrying that byte, in acceptance order.
- R7: The target gap T, in symbols, is `gap_cfg` limited to the range 8 to 12. Values 0 to 7 act as 8 and values 13 to 15 act as 12.
- R8: A credit bank of 0 to 3 bytes controls the gap. A new packet is admitted once the gap reaches T minus the bank. At each packet start the bank becomes the old bank plus (gap − T), limited to the range 0 to 3. Back-to-back packets after a long idle therefore see gaps of T−3 and then T.
- R9: No gap between two packets is shorter than 5 symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| force_idle | input | 1 | Send only idles between packets |
| force_rf | input | 1 | Send remote-fault words between packets |
| force_lf | input | 1 | Send local-fault words between packets (highest precedence) |
| gap_cfg | input | 4 | Target inter-packet gap in bytes |
| s_tdata | input | 8 | Stream data byte |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Last byte of packet |
| s_tready | output | 1 | Stream ready |
| sym_type | output | 2 | Symbol type: 0 idle, 1 data, 2 remote fault, 3 local fault |
| sym_data | output | 8 | Data byte for data symbols, zero otherwise |
| link_init | output | 1 | High while held in the initial state |

## Verification
The bench builds the block with its default parameters. These are an 8-bit data path, a gap range of 8 to 12, a floor of 5, a credit bank of 3 bytes and a 5-bit gap counter that saturates at 31. With these values, about thirty idle cycles are enough to fill the credit bank. That makes the shortened first gap and the following full gap predictable for every `gap_cfg` value in the table, including the clamped values 0, 7 and 15. A deliberately late source with `gap_cfg` 10 drives the bank from empty to a partial value of 2, which reaches the intermediate gap length of 8.

// File: rtl/txls_pkg.sv
package txls_pkg;

    typedef enum logic [1:0] {
        SYM_IDLE = 2'd0,
        SYM_DATA = 2'd1,
        SYM_RFLT = 2'd2,
        SYM_LFLT = 2'd3
    } sym_e;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_GAP  = 2'd1,
        ST_PKT  = 2'd2
    } seq_st_e;

    // non-data symbol chosen by the override inputs, local fault first
    function automatic sym_e pick_nondata(input logic lf, input logic rf);
        if (lf)      return SYM_LFLT;
        else if (rf) return SYM_RFLT;
        else         return SYM_IDLE;
    endfunction

endpackage

// File: rtl/txls_gap_ctrl.sv
module txls_gap_ctrl #(
    parameter int CFG_W      = 4,
    parameter int GAP_LO     = 8,
    parameter int GAP_HI     = 12,
    parameter int GAP_FLOOR  = 5,
    parameter int CREDIT_MAX = 3,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] gap_cfg,
    input  logic             beat_acc,
    input  logic             sop_acc,
    output logic             gap_open
);
    localparam int CR_W  = $clog2(CREDIT_MAX + 1);
    localparam int SW    = CNT_W + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CFG_W-1:0] LO_C    = CFG_W'(GAP_LO);
    localparam logic [CFG_W-1:0] HI_C    = CFG_W'(GAP_HI);
    localparam logic [CNT_W-1:0] FLOOR_C = CNT_W'(GAP_FLOOR);
    localparam logic [CR_W-1:0]  CRMAX_C = CR_W'(CREDIT_MAX);

    logic [CNT_W-1:0] idle_cnt_q;
    logic [CR_W-1:0]  bank_q;
    logic [CNT_W-1:0] target;
    logic signed [SW-1:0] balance;
    logic [CR_W-1:0]  bank_next;

    // clamp programmed gap into its meaningful range
    always_comb begin
        if (gap_cfg < LO_C)      target = CNT_W'(LO_C);
        else if (gap_cfg > HI_C) target = CNT_W'(HI_C);
        else                     target = CNT_W'(gap_cfg);
    end

    // symbols since the last accepted byte, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_cnt_q <= CNT_MAX;
        else if (beat_acc)          idle_cnt_q <= '0;
        else if (idle_cnt_q != CNT_MAX) idle_cnt_q <= idle_cnt_q + 1'b1;
    end

    // bank update at packet start: old bank plus gap excess over target
    always_comb begin
        balance = $signed(SW'(bank_q)) + $signed(SW'(idle_cnt_q)) - $signed(SW'(target));
        if (balance < 0)
            bank_next = '0;
        else if (balance > $signed(SW'(CRMAX_C)))
            bank_next = CRMAX_C;
        else
            bank_next = CR_W'(balance);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (sop_acc) bank_q <= bank_next;
    end

    assign gap_open = ((SW'(idle_cnt_q) + SW'(bank_q)) >= SW'(target))
                      && (idle_cnt_q >= FLOOR_C);

endmodule

// File: rtl/txls_sym_out.sv
module txls_sym_out
    import txls_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_acc,
    input  logic [DATA_W-1:0] beat_data,
    input  sym_e              nd_sym,
    output sym_e              sym_q,
    output logic [DATA_W-1:0] dat_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= SYM_IDLE;
            dat_q <= '0;
        end else if (beat_acc) begin
            sym_q <= SYM_DATA;
            dat_q <= beat_data;
        end else begin
            sym_q <= nd_sym;
            dat_q <= '0;
        end
    end
endmodule

// File: rtl/tx_link_seq.sv
module tx_link_seq
    import txls_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CFG_W      = 4,
    parameter int GAP_LO     = 8,
    parameter int GAP_HI     = 12,
    parameter int GAP_FLOOR  = 5,
    parameter int CREDIT_MAX = 3,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              force_idle,
    input  logic              force_rf,
    input  logic              force_lf,
    input  logic [CFG_W-1:0]  gap_cfg,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [1:0]        sym_type,
    output logic [DATA_W-1:0] sym_data,
    output logic              link_init
);
    seq_st_e st_q, st_d;
    logic    gap_open;
    logic    start_ok;
    logic    beat_acc;
    logic    sop_acc;
    sym_e    nd_sym;
    sym_e    sym_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end

    assign start_ok = gap_open && tx_en && !force_idle && !force_rf && !force_lf;
    assign beat_acc = s_tvalid && s_tready;
    assign sop_acc  = beat_acc && (st_q == ST_GAP);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT: if (tx_en) st_d = ST_GAP;
            ST_GAP:  if (beat_acc && !s_tlast) st_d = ST_PKT;
            ST_PKT:  if (beat_acc && s_tlast) st_d = ST_GAP;
            default: st_d = ST_INIT;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        s_tready  = 1'b0;
        link_init = 1'b0;
        unique case (st_q)
            ST_INIT: link_init = 1'b1;
            ST_GAP:  s_tready  = start_ok;
            ST_PKT:  s_tready  = 1'b1;
            default: link_init = 1'b1;
        endcase
    end

    assign nd_sym = (st_q == ST_PKT) ? SYM_IDLE : pick_nondata(force_lf, force_rf);

    txls_gap_ctrl #(
        .CFG_W(CFG_W), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI),
        .GAP_FLOOR(GAP_FLOOR), .CREDIT_MAX(CREDIT_MAX), .CNT_W(CNT_W)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .gap_cfg(gap_cfg),
        .beat_acc(beat_acc), .sop_acc(sop_acc), .gap_open(gap_open)
    );

    txls_sym_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .beat_acc(beat_acc), .beat_data(s_tdata),
        .nd_sym(nd_sym), .sym_q(sym_q), .dat_q(sym_data)
    );

    assign sym_type = sym_q;

endmodule

// File: rtl/txls_checker.sv
module txls_checker #(
    parameter int DATA_W    = 8,
    parameter int GAP_FLOOR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              force_idle,
    input logic              force_rf,
    input logic              force_lf,
    input logic [DATA_W-1:0] s_tdata,
    input logic              s_tvalid,
    input logic              s_tlast,
    input logic              s_tready,
    input logic [1:0]        sym_type,
    input logic [DATA_W-1:0] sym_data,
    input logic              link_init
);
    logic       in_pkt;
    logic       seen_pkt;
    logic [5:0] nd_run;
    logic       acc;

    assign acc = s_tvalid && s_tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt   <= 1'b0;
            seen_pkt <= 1'b0;
            nd_run   <= '0;
        end else begin
            if (acc) begin
                in_pkt   <= !s_tlast;
                seen_pkt <= 1'b1;
                nd_run   <= '0;
            end else if (nd_run != 6'h3f) begin
                nd_run <= nd_run + 1'b1;
            end
        end
    end

    // R1
    init_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_init |-> !s_tready);

    // R2
    lf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_lf && !s_tready && !in_pkt) |=> (sym_type == 2'd3));

    // R3
    rf_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_rf && !force_lf && !s_tready && !in_pkt) |=> (sym_type == 2'd2));

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready && !in_pkt) |-> (tx_en && !force_idle && !force_rf && !force_lf));

    // R5
    pkt_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !s_tlast) |=> s_tready);

    // R6
    data_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (sym_type == 2'd1 && sym_data == $past(s_tdata)));

    // R9
    gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_pkt && seen_pkt) |-> (nd_run >= 6'(GAP_FLOOR)));

endmodule

bind tx_link_seq txls_checker #(.DATA_W(DATA_W), .GAP_FLOOR(GAP_FLOOR)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .force_idle(force_idle),
    .force_rf(force_rf), .force_lf(force_lf), .s_tdata(s_tdata),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .sym_type(sym_type), .sym_data(sym_data), .link_init(link_init)
);

// File: tb/tb_tx_link_seq.sv
module tb_tx_link_seq;
    localparam int LOGN = 2048;
    // {cfg, len, first gap, second gap}
    localparam logic [15:0] VEC [6] = '{16'h0458, 16'h7158, 16'h8658,
                                        16'hA37A, 16'hC59C, 16'hF29C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, force_idle = 1'b0, force_rf = 1'b0, force_lf = 1'b0;
    logic [3:0] gap_cfg = 4'd12;
    logic [7:0] s_tdata = '0;
    logic       s_tvalid = 1'b0, s_tlast = 1'b0;
    logic       s_tready;
    logic [1:0] sym_type;
    logic [7:0] sym_data;
    logic       link_init;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic       rec = 1'b0;
    int         idx = 0;
    logic [1:0] lt [LOGN];
    logic [7:0] ld [LOGN];
    int         gaps [16];
    int         ng, nd, ne, bad;
    logic [7:0] eb [128];

    always #4 clk = ~clk;

    tx_link_seq dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .force_idle(force_idle),
        .force_rf(force_rf), .force_lf(force_lf), .gap_cfg(gap_cfg),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready), .sym_type(sym_type), .sym_data(sym_data),
        .link_init(link_init)
    );

    always @(negedge clk) begin
        if (rec && idx < LOGN) begin
            lt[idx] = sym_type;
            ld[idx] = sym_data;
            idx = idx + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(input int len, input logic [7:0] base,
                            input int act_at, input int act);
        for (int i = 0; i < len; i++) begin
            bit ok;
            if (i == act_at) begin
                if (act == 1) tx_en = 1'b0;
                if (act == 2) force_lf = 1'b1;
            end
            s_tvalid = 1'b1;
            s_tdata  = base + 8'(i);
            s_tlast  = (i == len - 1);
            if (ne < 128) begin eb[ne] = s_tdata; ne++; end
            ok = 0;
            while (!ok) begin
                #1 ok = s_tready;
                @(negedge clk);
            end
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    // presents a byte for n cycles, returns how often ready was seen
    task automatic offer(input int n, output int hits);
        hits = 0;
        s_tvalid = 1'b1;
        s_tdata  = 8'hEE;
        s_tlast  = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1 if (s_tready) hits++;
            @(negedge clk);
        end
        s_tvalid = 1'b0;
    endtask

    task automatic measure(input int s, input int e);
        bit in_d, seen;
        int run;
        ng = 0; nd = 0; bad = 0; in_d = 0; seen = 0; run = 0;
        for (int k = s; k < e; k++) begin
            if (lt[k] == 2'd1) begin
                if (!in_d && seen && ng < 16) begin gaps[ng] = run; ng++; end
                in_d = 1; seen = 1;
                if (nd < ne && ld[k] != eb[nd]) bad++;
                nd++;
            end else begin
                if (in_d) begin in_d = 0; run = 0; end
                run++;
            end
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s, h;
        rec = 1'b1;
        cyc(4);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 init after reset", link_init, 1);
        chk("R1 ready low after reset", s_tready, 0);
        chk("R1 idle symbol after reset", sym_type, 0);
        @(negedge clk);
        offer(10, h);
        chk("R1 R4 no ready while disabled in init", h, 0);
        chk("R1 still init", link_init, 1);
        tx_en = 1'b1;
        cyc(2);
        chk("R1 init released", link_init, 0);

        // table walk: R7 R8 R9 R6
        foreach (VEC[v]) begin
            int len, e0, e1;
            gap_cfg = VEC[v][15:12];
            len = int'(VEC[v][11:8]);
            e0  = int'(VEC[v][7:4]);
            e1  = int'(VEC[v][3:0]);
            cyc(40);
            s = idx; ne = 0;
            send_pkt(len, 8'(v * 16), -1, 0);
            send_pkt(len, 8'(v * 16 + 5), -1, 0);
            send_pkt(len, 8'(v * 16 + 9), -1, 0);
            cyc(20);
            measure(s, idx);
            chk($sformatf("R8 R9 first gap cfg=%0d", gap_cfg), gaps[0], e0);
            chk($sformatf("R7 R8 second gap cfg=%0d", gap_cfg), gaps[1], e1);
            chk("R6 data byte count", nd, 3 * len);
            chk("R6 data byte mismatches", bad, 0);
        end

        // R8 partial credit from a late source
        gap_cfg = 4'd10;
        cyc(40);
        s = idx; ne = 0;
        send_pkt(3, 8'h40, -1, 0);
        send_pkt(3, 8'h50, -1, 0);
        cyc(12);
        send_pkt(3, 8'h60, -1, 0);
        send_pkt(3, 8'h70, -1, 0);
        send_pkt(3, 8'h80, -1, 0);
        cyc(20);
        measure(s, idx);
        chk("R8 banked gap", gaps[0], 7);
        chk("R8 late gap", gaps[1], 12);
        chk("R8 partial credit gap", gaps[2], 8);
        chk("R7 R8 repaid gap", gaps[3], 10);
        chk("R6 credit data", bad, 0);

        // R2 R3 R4 overrides between packets
        force_lf = 1'b1; force_rf = 1'b1;
        cyc(3);
        chk("R2 local fault wins", sym_type, 3);
        offer(5, h);
        chk("R2 no ready under local fault", h, 0);
        force_lf = 1'b0;
        cyc(2);
        chk("R3 remote fault word", sym_type, 2);
        force_rf = 1'b0; force_idle = 1'b1;
        cyc(2);
        s = idx;
        offer(10, h);
        chk("R4 forced idle blocks ready", h, 0);
        chk("R4 forced idle symbol", sym_type, 0);
        ne = 0;
        measure(s, idx);
        chk("R4 no data under forced idle", nd, 0);
        force_idle = 1'b0;
        cyc(30);

        // R5 transmit disabled mid-packet
        s = idx; ne = 0;
        send_pkt(8, 8'hA0, 3, 1);
        cyc(3);
        measure(s, idx);
        chk("R5 packet completes after disable", nd, 8);
        chk("R5 bytes intact after disable", bad, 0);
        offer(20, h);
        chk("R5 no new packet after disable", h, 0);
        chk("R4 idle while disabled", sym_type, 0);
        tx_en = 1'b1;
        cyc(40);

        // R5 R2 local fault mid-packet
        s = idx; ne = 0;
        send_pkt(6, 8'hC0, 2, 2);
        cyc(4);
        measure(s, idx);
        chk("R5 packet completes under fault", nd, 6);
        chk("R5 bytes intact under fault", bad, 0);
        chk("R2 fault words after packet", sym_type, 3);
        force_lf = 1'b0;
        cyc(4);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule